// File: doc/BRIEF.md
# Burst-Aware Lock-Honouring Bus Arbiter

This block decides which of several masters drives a shared pipelined bus. Each master raises a request line and, for atomic sequences, a lock line. The arbiter watches the transfer type, burst type, ready and response lines of the bus and chooses the moment at which ownership may move. An unlocked single transfer or an undefined-length burst may be preempted on any accepted beat. A fixed-length burst keeps the bus until its second-to-last address phase is accepted, so its owner still issues the final beat. A locked sequence keeps the bus for as long as lock is held, plus one more ready cycle.

A SPLIT response inside a locked sequence moves the grant to a reserved dummy master, which only issues IDLE transfers. The bus stays parked there until the slave releases the split master, and that master is then regranted to finish its sequence. A master that is split outside a lock is only removed from arbitration until its release bit arrives. Among eligible requesters, a round-robin rotation starts from the master after the last one granted. A fixed lowest-index-first order is available as a parameter variant.

Top module: `bus_arbiter`

## Requirements
- R1: On synchronous reset the grant goes to master 0: `grant` = 0001, `grant_dummy` = 0, `owner` = 0 and `owner_locked` = 0.
- R2: The grant, `grant_dummy`, `owner` and `owner_locked` change only on a clock edge where `hready` is 1.
- R3: When the holder is neither locked nor inside a fixed burst, the grant goes on the next ready edge to the first requesting, unmasked master found by rotating upward from the holder's index + 1.
- R4: When no eligible master requests, the grant goes to the default master 0.
- R5: Burst encoding `hburst`: 000 single, 001 undefined-length, 01x 4 beats, 10x 8 beats, 11x 16 beats. A beat counts only on a ready cycle whose `htrans` is NONSEQ (10) or SEQ (11); BUSY (01) does not count. A fixed burst keeps the grant until the edge at which its second-to-last beat is accepted.
- R6: In an unlocked undefined-length burst the grant may move at any accepted beat, including the first.
- R7: While the holder's lock input is 1, the grant never moves, whatever the burst type. After the lock drops, the grant stays with the holder for one more ready edge before rearbitration.
- R8: On each ready edge, `owner` takes the index that was granted before that edge, and `owner_locked` takes that master's lock input. The dummy master has index 4 and never shows as locked.
- R9: A SPLIT response (`hresp` = 11) accepted with `hready` = 1 while `owner_locked` is 1 moves the grant to the dummy master (`grant` = 0000, `grant_dummy` = 1). The grant stays there, ignoring other requests, until the edge after that master's `split_release` bit is seen, and then returns to the split master.
- R10: A SPLIT response outside a lock removes the grant from the split master at once and masks that master from arbitration. The mask stays until its `split_release` bit is seen, and the bit takes effect from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MST | Per-master bus request |
| mst_lock | input | N_MST | Per-master locked-sequence request |
| htrans | input | 2 | Bus transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hburst | input | 3 | Bus burst type |
| hready | input | 1 | Bus ready, transfer accepted |
| hresp | input | 2 | Slave response, 11 is SPLIT |
| split_release | input | N_MST | Per-master release of a split |
| grant | output | N_MST | One-hot grant to real masters |
| grant_dummy | output | 1 | Grant to the dummy master |
| owner | output | IDX_W | Index of the address-phase owner, N_MST for the dummy |
| owner_locked | output | 1 | Current address phase belongs to a locked sequence |

## Verification
A wrong beat count in the burst tracker shows on `grant` one ready edge early or late relative to the second-to-last beat of an INCR4 burst, and BUSY cycles are inserted to expose miscounting. A stale lock state shows as a grant that moves while lock is high, or that lingers beyond the single extra IDLE edge. A lost park index or split mask shows within one or two ready edges, as a regrant to the wrong master or as a masked master winning. Every ready edge is compared against an expected grant, owner and lock triple, so a fault is reported in the cycle where it first reaches the ports.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_t;

  localparam logic [1:0] RESP_SPLIT = 2'b11;
  localparam int         BEAT_W     = 4;

  // Beats still to come after the first beat of a burst; 0 for single and
  // undefined-length bursts.
  function automatic logic [BEAT_W-1:0] burst_tail(input logic [2:0] kind);
    case (kind[2:1])
      2'b00:   return '0;
      2'b01:   return BEAT_W'(3);
      2'b10:   return BEAT_W'(7);
      default: return BEAT_W'(15);
    endcase
  endfunction

endpackage

// File: rtl/beat_tracker.sv
module beat_tracker
  import arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hready,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic              flush,
  output logic [BEAT_W-1:0] left_next
);

  logic [BEAT_W-1:0] left_q;

  always_comb begin
    left_next = left_q;
    if (flush) begin
      left_next = '0;
    end else if (hready) begin
      case (trans_t'(htrans))
        TR_NONSEQ: left_next = burst_tail(hburst);
        TR_SEQ:    left_next = (left_q != '0) ? left_q - BEAT_W'(1) : '0;
        TR_IDLE:   left_next = '0;
        default:   left_next = left_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) left_q <= '0;
    else     left_q <= left_next;
  end

endmodule

// File: rtl/winner_pick.sv
module winner_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 3,
  parameter bit RR    = 1'b1
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] win,
  output logic             found
);

  generate
    if (RR) begin : g_rotate
      always_comb begin
        win   = '0;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
          int pos;
          pos = (int'(last) + k) % N;
          if (!found && cand[pos]) begin
            found = 1'b1;
            win   = IDX_W'(pos);
          end
        end
      end
    end else begin : g_fixed
      always_comb begin
        win   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
          if (cand[i]) begin
            found = 1'b1;
            win   = IDX_W'(i);
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/split_track.sv
module split_track #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] release_vec,
  output logic [N-1:0] mask
);

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else     mask <= (mask & ~release_vec) | (set_en ? set_vec : '0);
  end

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_MST       = 4,
  parameter bit ROUND_ROBIN = 1'b1,
  parameter int DEF_MST     = 0,
  localparam int IDX_W      = $clog2(N_MST + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] req,
  input  logic [N_MST-1:0] mst_lock,
  input  logic [1:0]       htrans,
  input  logic [2:0]       hburst,
  input  logic             hready,
  input  logic [1:0]       hresp,
  input  logic [N_MST-1:0] split_release,
  output logic [N_MST-1:0] grant,
  output logic             grant_dummy,
  output logic [IDX_W-1:0] owner,
  output logic             owner_locked
);

  localparam logic [IDX_W-1:0] DUMMY = IDX_W'(N_MST);
  localparam logic [IDX_W-1:0] DEF   = IDX_W'(DEF_MST);

  logic [IDX_W-1:0]  gidx_q, gidx_n;
  logic [IDX_W-1:0]  park_idx_q, park_idx_n;
  logic              park_q, park_n;
  logic [N_MST-1:0]  grant_n;
  logic [N_MST-1:0]  own_bit;
  logic [N_MST-1:0]  mask_q;
  logic [N_MST-1:0]  cand_norm, cand_split;
  logic [IDX_W-1:0]  win_norm, win_split;
  logic              found_norm, found_split;
  logic [BEAT_W-1:0] left_next;
  logic              split_ev, cur_lock, hold_lock, may_move;

  assign split_ev  = hready && (hresp == RESP_SPLIT);
  assign cur_lock  = (gidx_q != DUMMY) && mst_lock[gidx_q];
  assign hold_lock = cur_lock || owner_locked;

  always_comb begin
    for (int i = 0; i < N_MST; i++) begin
      own_bit[i] = (owner == IDX_W'(i));
      grant_n[i] = (gidx_n == IDX_W'(i));
    end
  end

  assign cand_norm  = req & ~mask_q;
  assign cand_split = req & ~(mask_q | own_bit);

  beat_tracker u_beats (
    .clk       (clk),
    .rst       (rst),
    .hready    (hready),
    .htrans    (htrans),
    .hburst    (hburst),
    .flush     (split_ev),
    .left_next (left_next)
  );

  split_track #(.N(N_MST)) u_split (
    .clk         (clk),
    .rst         (rst),
    .set_en      (split_ev),
    .set_vec     (own_bit),
    .release_vec (split_release),
    .mask        (mask_q)
  );

  winner_pick #(.N(N_MST), .IDX_W(IDX_W), .RR(ROUND_ROBIN)) u_pick_norm (
    .cand  (cand_norm),
    .last  (gidx_q),
    .win   (win_norm),
    .found (found_norm)
  );

  winner_pick #(.N(N_MST), .IDX_W(IDX_W), .RR(ROUND_ROBIN)) u_pick_split (
    .cand  (cand_split),
    .last  (gidx_q),
    .win   (win_split),
    .found (found_split)
  );

  // Handover is allowed once the beat accepted now leaves at most one beat.
  assign may_move = !hold_lock && (left_next <= BEAT_W'(1));

  always_comb begin
    gidx_n     = gidx_q;
    park_n     = park_q;
    park_idx_n = park_idx_q;
    if (hready) begin
      if (split_ev && owner_locked) begin
        gidx_n     = DUMMY;
        park_n     = 1'b1;
        park_idx_n = owner;
      end else if (park_q) begin
        if (!mask_q[park_idx_q]) begin
          gidx_n = park_idx_q;
          park_n = 1'b0;
        end
      end else if (split_ev) begin
        gidx_n = found_split ? win_split : DEF;
      end else if (may_move) begin
        gidx_n = found_norm ? win_norm : DEF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gidx_q       <= DEF;
      park_q       <= 1'b0;
      park_idx_q   <= '0;
      grant        <= N_MST'(1) << DEF_MST;
      grant_dummy  <= 1'b0;
      owner        <= DEF;
      owner_locked <= 1'b0;
    end else begin
      gidx_q      <= gidx_n;
      park_q      <= park_n;
      park_idx_q  <= park_idx_n;
      grant       <= grant_n;
      grant_dummy <= (gidx_n == DUMMY);
      if (hready) begin
        owner        <= gidx_q;
        owner_locked <= cur_lock;
      end
    end
  end

endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
  parameter int N_MST = 4,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N_MST-1:0] mst_lock,
  input logic             hready,
  input logic [1:0]       hresp,
  input logic [N_MST-1:0] grant,
  input logic             grant_dummy,
  input logic [IDX_W-1:0] owner,
  input logic             owner_locked
);

  logic [IDX_W-1:0] gid;

  always_comb begin
    gid = IDX_W'(N_MST);
    for (int i = 0; i < N_MST; i++)
      if (grant[i]) gid = IDX_W'(i);
  end

  AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (rst)
    $countones({grant_dummy, grant}) == 1);                                            // R3
  AST_STILL_WHEN_WAIT: assert property (@(posedge clk) disable iff (rst)
    !hready |=> ($stable(grant) && $stable(grant_dummy) && $stable(owner)));           // R2
  AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (hready && |(grant & mst_lock) && hresp != 2'b11) |=> $stable(grant));             // R7
  AST_OWNER_TRAILS: assert property (@(posedge clk) disable iff (rst)
    hready |=> (owner == $past(gid)));                                                 // R8
  AST_PARK_ON_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (hready && hresp == 2'b11 && owner_locked) |=> grant_dummy);                       // R9
  AST_DUMMY_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    (owner == IDX_W'(N_MST)) |-> !owner_locked);                                       // R8

endmodule

bind bus_arbiter bus_arbiter_chk #(.N_MST(N_MST), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mst_lock     (mst_lock),
  .hready       (hready),
  .hresp        (hresp),
  .grant        (grant),
  .grant_dummy  (grant_dummy),
  .owner        (owner),
  .owner_locked (owner_locked)
);

// File: tb/tb_bus_arbiter.sv
`timescale 1ns/1ps
module tb_bus_arbiter;

  localparam logic [1:0] IDL = 2'b00, BSY = 2'b01, NSQ = 2'b10, SQ = 2'b11;
  localparam logic [1:0] OK = 2'b00, SPL = 2'b11;
  localparam logic [2:0] SGL = 3'b000, INC = 3'b001, I4 = 3'b011;

  typedef struct packed {
    logic [3:0] g;
    logic       d;
    logic [2:0] o;
    logic       l;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0, mst_lock = '0, split_release = '0;
  logic [1:0] htrans = IDL, hresp = OK;
  logic [2:0] hburst = SGL;
  logic       hready = 1'b1;
  logic [3:0] grant;
  logic       grant_dummy;
  logic [2:0] owner;
  logic       owner_locked;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  bus_arbiter dut (
    .clk(clk), .rst(rst), .req(req), .mst_lock(mst_lock), .htrans(htrans),
    .hburst(hburst), .hready(hready), .hresp(hresp), .split_release(split_release),
    .grant(grant), .grant_dummy(grant_dummy), .owner(owner), .owner_locked(owner_locked)
  );

  function automatic void compare(input exp_t e, input string t);
    checks++;
    if ({grant, grant_dummy, owner, owner_locked} !== e) begin
      errors++;
      $display("FAIL %s: got grant=%b dummy=%b owner=%0d lock=%b, expected grant=%b dummy=%b owner=%0d lock=%b",
               t, grant, grant_dummy, owner, owner_locked, e.g, e.d, e.o, e.l);
    end
  endfunction

  // Driver: apply one cycle of bus stimulus and queue the state expected after the next edge.
  task automatic step(input logic [3:0] r, input logic [3:0] lk, input logic [1:0] tr,
                      input logic [2:0] bu, input logic rdy, input logic [1:0] rs,
                      input logic [3:0] rel, input logic [3:0] eg, input logic ed,
                      input logic [2:0] eo, input logic el, input string t);
    @(negedge clk);
    req = r; mst_lock = lk; htrans = tr; hburst = bu; hready = rdy; hresp = rs;
    split_release = rel;
    exp_q.push_back('{g: eg, d: ed, o: eo, l: el});
    tag_q.push_back(t);
  endtask

  // Monitor: one expected item per edge, sampled shortly after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare('{g: 4'b0001, d: 1'b0, o: 3'd0, l: 1'b0}, "R1 reset state");
    rst = 1'b0;
    // R4 nobody asks
    step(4'b0000, 4'b0000, IDL, SGL, 1, OK, 4'b0000, 4'b0001, 0, 0, 0, "R4 idle default");
    // R3 rotation and preemption of single transfers
    step(4'b0100, 4'b0000, IDL, SGL, 1, OK, 4'b0000, 4'b0100, 0, 0, 0, "R3 move to m2");
    step(4'b0100, 4'b0000, IDL, SGL, 1, OK, 4'b0000, 4'b0100, 0, 2, 0, "R8 owner trails");
    step(4'b0010, 4'b0000, IDL, SGL, 0, OK, 4'b0000, 4'b0100, 0, 2, 0, "R2 wait state");
    step(4'b0010, 4'b0000, IDL, SGL, 1, OK, 4'b0000, 4'b0010, 0, 2, 0, "R3 preempt to m1");
    // R5 fixed 4-beat burst with BUSY and wait
    step(4'b1010, 4'b0000, NSQ, I4,  1, OK, 4'b0000, 4'b0010, 0, 1, 0, "R5 first beat");
    step(4'b1010, 4'b0000, SQ,  I4,  1, OK, 4'b0000, 4'b0010, 0, 1, 0, "R5 second beat");
    step(4'b1010, 4'b0000, BSY, I4,  1, OK, 4'b0000, 4'b0010, 0, 1, 0, "R5 busy uncounted");
    step(4'b1010, 4'b0000, SQ,  I4,  0, OK, 4'b0000, 4'b0010, 0, 1, 0, "R2 burst wait");
    step(4'b1010, 4'b0000, SQ,  I4,  1, OK, 4'b0000, 4'b1000, 0, 1, 0, "R5 handover third beat");
    step(4'b1000, 4'b0000, SQ,  I4,  1, OK, 4'b0000, 4'b1000, 0, 3, 0, "R5 last beat");
    // R6 undefined-length burst preempted at first beat
    step(4'b1001, 4'b0000, NSQ, INC, 1, OK, 4'b0000, 4'b0001, 0, 3, 0, "R6 incr preempt");
    // R7 lock holds over undefined burst, then one extra edge
    step(4'b0001, 4'b0001, IDL, SGL, 1, OK, 4'b0000, 4'b0001, 0, 0, 1, "R7 lock start");
    step(4'b0011, 4'b0001, NSQ, INC, 1, OK, 4'b0000, 4'b0001, 0, 0, 1, "R7 lock over incr");
    step(4'b0011, 4'b0001, SQ,  INC, 1, OK, 4'b0000, 4'b0001, 0, 0, 1, "R7 lock beat");
    step(4'b0010, 4'b0000, IDL, SGL, 1, OK, 4'b0000, 4'b0001, 0, 0, 0, "R7 extra idle");
    step(4'b0010, 4'b0000, IDL, SGL, 1, OK, 4'b0000, 4'b0010, 0, 0, 0, "R7 release");
    // R9 split inside a locked sequence
    step(4'b0010, 4'b0010, NSQ, SGL, 1, OK,  4'b0000, 4'b0010, 0, 1, 1, "R8 owner locked");
    step(4'b0010, 4'b0010, IDL, SGL, 0, SPL, 4'b0000, 4'b0010, 0, 1, 1, "R2 split first cycle");
    step(4'b0110, 4'b0010, IDL, SGL, 1, SPL, 4'b0000, 4'b0000, 1, 1, 1, "R9 park on dummy");
    step(4'b0110, 4'b0000, IDL, SGL, 1, OK,  4'b0000, 4'b0000, 1, 4, 0, "R9 parked");
    step(4'b0110, 4'b0000, IDL, SGL, 1, OK,  4'b0010, 4'b0000, 1, 4, 0, "R9 release seen");
    step(4'b0110, 4'b0010, IDL, SGL, 1, OK,  4'b0000, 4'b0010, 0, 4, 0, "R9 regrant");
    step(4'b0110, 4'b0010, IDL, SGL, 1, OK,  4'b0000, 4'b0010, 0, 1, 1, "R7 relock");
    step(4'b0100, 4'b0000, IDL, SGL, 1, OK,  4'b0000, 4'b0010, 0, 1, 0, "R7 extra idle 2");
    step(4'b0100, 4'b0000, IDL, SGL, 1, OK,  4'b0000, 4'b0100, 0, 1, 0, "R3 to m2");
    // R10 split outside a lock
    step(4'b0100, 4'b0000, NSQ, SGL, 1, OK,  4'b0000, 4'b0100, 0, 2, 0, "R3 keep m2");
    step(4'b0100, 4'b0000, IDL, SGL, 0, SPL, 4'b0000, 4'b0100, 0, 2, 0, "R10 split wait");
    step(4'b0101, 4'b0000, IDL, SGL, 1, SPL, 4'b0000, 4'b0001, 0, 2, 0, "R10 split move");
    step(4'b0100, 4'b0000, IDL, SGL, 1, OK,  4'b0000, 4'b0001, 0, 0, 0, "R10 masked ignored");
    step(4'b0100, 4'b0000, IDL, SGL, 1, OK,  4'b0100, 4'b0001, 0, 0, 0, "R10 release pending");
    step(4'b0100, 4'b0000, IDL, SGL, 1, OK,  4'b0000, 4'b0100, 0, 0, 0, "R10 unmasked");
    @(negedge clk);
    req = '0; split_release = '0;
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule